// File: doc/BRIEF.md
# Core Interrupt Countdown Timer

This block is the countdown timer that sits beside each processor's local interrupt controller. Software programs it through a small 32-bit register window. One register holds a timer entry: an interrupt vector, a mask bit and a mode bit that selects one-shot or periodic operation. A second register holds a start count. A third holds a divide code that sets how many clock cycles make one timer tick. Writing the start count loads the timer and restarts it. A read-only register returns the live count. A spurious-vector register, which resets to 0xFF, also lives in the window.

On each expiry the timer raises a request that lasts one cycle and carries the programmed vector, unless the entry is masked at that moment. Counting does not depend on the mask. In periodic mode the count runs from the start value down to zero. On the next tick it reloads and raises a request, so one period lasts start count plus one ticks. In one-shot mode the count runs down to zero, raises one request as it reaches zero, and then stays at zero. A start count of zero leaves the timer idle, and it raises no request.

The counter is a three-state machine:
- ST_IDLE: nothing is loaded.
- ST_RUN: the timer is counting.
- ST_HOLD: a one-shot run has finished and the count stays at zero.

The transitions are:
- load-nonzero: any state goes to ST_RUN when a nonzero start count is written.
- load-zero: any state goes to ST_IDLE when a zero start count is written.
- oneshot-expire: ST_RUN goes to ST_HOLD on the tick that takes the count from 1 to 0. This transition raises a request.
- oneshot-drain: ST_RUN goes to ST_HOLD, with no request, when a one-shot tick finds the count already at 0. This happens only after the mode was switched during a run.
- periodic-wrap: ST_RUN stays in ST_RUN on a tick at count 0. The count reloads and a request is raised.

Top module: `core_irq_timer`

## Requirements
- R1: After reset the registers read as follows: the entry register (0x320) reads 0x0001_0000, which is mask set, one-shot, vector 0. The start count (0x380), the live count (0x390) and the divide register (0x3E0) read 0. The spurious register (0x0F0) reads 0x0000_00FF. No request is raised.
- R2: The divide code is made from write-data bits 3, 1 and 0. With sel = {bit3,bit1,bit0}, the shift is (sel+1) mod 8. Code 0b1011 therefore means divide by 1, 0b0000 divide by 2, 0b0001 divide by 4, 0b1000 divide by 32 and 0b1010 divide by 128. Elapsed ticks equal the clock cycles since the start-count write, shifted right by that amount.
- R3: In one-shot mode (entry bit 17 = 0) the live count reads as start minus elapsed ticks while elapsed ticks are below the start count. From then on it reads 0.
- R4: A one-shot run raises exactly one request, in the cycle after the count reaches 0, and then raises no further request until a new load.
- R5: In periodic mode (entry bit 17 = 1) the live count reads as start minus (elapsed ticks mod (start+1)).
- R6: In periodic mode a request is raised each time elapsed ticks reach a nonzero multiple of start+1.
- R7: A start count of zero raises no request and the live count reads 0.
- R8: While the entry's mask bit (bit 16) is set, no request is raised, but counting continues. The mask is sampled in the cycle before the request would be raised.
- R9: Writing the start count while the timer runs restarts counting from the new value, and elapsed ticks are measured from that write.
- R10: The entry register keeps bits 17, 16 and 7:0 and reads the other bits as 0. The divide register keeps bits 3, 1 and 0. The spurious register keeps bits 7:0. The live count ignores writes.
- R11: The request output is high for one cycle at a time, and the vector output then holds the entry's vector as it was at the moment of expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_req | output | 1 | One-cycle interrupt request on expiry |
| irq_vec | output | 8 | Vector carried with irq_req |

## Verification
The main function is driven with these patterns:

| Pattern | What it shows |
|---|---|
| One-shot loads at divide-by-1 | An off-by-one between expiry at zero and wrap at start+1 |
| Periodic loads with a small start count, read at points inside and across periods | The mod (start+1) period from a plain start-count period |
| Divide codes 1, 2, 4, 32 and 128 | Whether the shift is decoded from the right bits and as sel+1 |
| A zero start count, a masked run that is then unmasked, and a restart in mid-count | The idle, mask and reload paths from normal counting |

Request counts and the vector are compared at read points that avoid the cycles in which a request fires.

// File: rtl/cit_pkg.sv
package cit_pkg;

    localparam int unsigned DIV_SHIFT_W = 3;
    localparam int unsigned MASK_BIT    = 16;
    localparam int unsigned MODE_BIT    = 17;

    localparam logic [11:0] OFS_SPUR  = 12'h0F0;
    localparam logic [11:0] OFS_ENTRY = 12'h320;
    localparam logic [11:0] OFS_START = 12'h380;
    localparam logic [11:0] OFS_LIVE  = 12'h390;
    localparam logic [11:0] OFS_DIV   = 12'h3E0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } tmr_state_e;

    // divide code bits {3,1,0} plus one, wrapping: 3'b111 -> shift 0
    function automatic logic [DIV_SHIFT_W-1:0] div_shift(input logic [3:0] code);
        logic [DIV_SHIFT_W-1:0] sel;
        sel = {code[3], code[1:0]};
        return sel + 1'b1;
    endfunction

endpackage

// File: rtl/cit_prescaler.sv
module cit_prescaler #(
    parameter int unsigned SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [SHIFT_W-1:0] shift_i,
    output logic               tick
);
    localparam int unsigned PRE_W = (1 << SHIFT_W) - 1;

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] lim;

    always_comb begin
        lim  = ~({PRE_W{1'b1}} << shift_i);
        tick = ((cnt_q & lim) == lim);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && shift_i != '0) |=> (!tick || shift_i == '0));

endmodule

// File: rtl/cit_counter.sv
module cit_counter
    import cit_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             periodic,
    input  logic             mask,
    input  logic [VEC_W-1:0] vector,
    output logic [CNT_W-1:0] start_o,
    output logic [CNT_W-1:0] live_o,
    output logic             irq_o,
    output logic [VEC_W-1:0] irq_vec_o
);
    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cur_q, cur_d, start_q;
    logic             expire;

    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        expire  = 1'b0;
        if (load) begin
            cur_d   = load_val;
            state_d = (load_val == '0) ? ST_IDLE : ST_RUN;
        end else if (tick) begin
            unique case (state_q)
                ST_IDLE, ST_HOLD: ;
                ST_RUN: begin
                    if (periodic) begin
                        if (cur_q == '0) begin
                            cur_d  = start_q;
                            expire = 1'b1;
                        end else begin
                            cur_d = cur_q - 1'b1;
                        end
                    end else if (cur_q == '0) begin
                        state_d = ST_HOLD;
                    end else if (cur_q == CNT_W'(1)) begin
                        cur_d   = '0;
                        state_d = ST_HOLD;
                        expire  = 1'b1;
                    end else begin
                        cur_d = cur_q - 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            start_q <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            if (load) start_q <= load_val;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o     <= 1'b0;
            irq_vec_o <= '0;
        end else begin
            irq_o <= expire && !mask;
            if (expire) irq_vec_o <= vector;
        end
    end

    assign start_o = start_q;
    assign live_o  = cur_q;

    // R4
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (cur_q == '0));
    // R11
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    // R8
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !$past(mask));
    // R3
    live_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q <= start_q);
    // R7
    zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val == '0) |=> (state_q == ST_IDLE && !irq_o));

endmodule

// File: rtl/core_irq_timer.sv
module core_irq_timer
    import cit_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec
);
    logic [VEC_W-1:0]       vec_q;
    logic                   mask_q, periodic_q;
    logic [3:0]             div_q;
    logic [VEC_W-1:0]       spur_q;
    logic                   load, tick;
    logic [CNT_W-1:0]       start_val, live_val;
    logic [DIV_SHIFT_W-1:0] shift;

    assign load  = reg_wr && (reg_addr == ADDR_W'(OFS_START));
    assign shift = div_shift(div_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q      <= '0;
            mask_q     <= 1'b1;
            periodic_q <= 1'b0;
            div_q      <= '0;
            spur_q     <= '1;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_W'(OFS_ENTRY)) begin
                vec_q      <= reg_wdata[VEC_W-1:0];
                mask_q     <= reg_wdata[MASK_BIT];
                periodic_q <= reg_wdata[MODE_BIT];
            end
            if (reg_addr == ADDR_W'(OFS_DIV))
                div_q <= {reg_wdata[3], 1'b0, reg_wdata[1:0]};
            if (reg_addr == ADDR_W'(OFS_SPUR))
                spur_q <= reg_wdata[VEC_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFS_ENTRY)) begin
            reg_rdata[VEC_W-1:0] = vec_q;
            reg_rdata[MASK_BIT]  = mask_q;
            reg_rdata[MODE_BIT]  = periodic_q;
        end else if (reg_addr == ADDR_W'(OFS_START)) begin
            reg_rdata[CNT_W-1:0] = start_val;
        end else if (reg_addr == ADDR_W'(OFS_LIVE)) begin
            reg_rdata[CNT_W-1:0] = live_val;
        end else if (reg_addr == ADDR_W'(OFS_DIV)) begin
            reg_rdata[3:0] = div_q;
        end else if (reg_addr == ADDR_W'(OFS_SPUR)) begin
            reg_rdata[VEC_W-1:0] = spur_q;
        end
    end

    cit_prescaler #(.SHIFT_W(DIV_SHIFT_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (load),
        .shift_i (shift),
        .tick    (tick)
    );

    cit_counter #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_val  (reg_wdata[CNT_W-1:0]),
        .tick      (tick),
        .periodic  (periodic_q),
        .mask      (mask_q),
        .vector    (vec_q),
        .start_o   (start_val),
        .live_o    (live_val),
        .irq_o     (irq_req),
        .irq_vec_o (irq_vec)
    );

    // R1
    reset_mask_chk: assert property (@(posedge clk)
        !rst_n |=> (mask_q && !irq_req && spur_q == '1));

endmodule

// File: tb/test_core_irq_timer.sv
`timescale 1ns/1ps
module test_core_irq_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic [7:0]  irq_vec;

    int checks = 0, errors = 0;
    int irq_cnt = 0, run_len = 0, max_run = 0, base = 0;
    logic [7:0] last_vec = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    event        chk_ev;

    always #10 clk = ~clk;

    core_irq_timer i_core_irq_timer (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_vec(irq_vec)
    );

    // request monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_req) begin
                irq_cnt++;
                last_vec = irq_vec;
                run_len++;
                if (run_len > max_run) max_run = run_len;
            end else begin
                run_len = 0;
            end
        end
    end

    // read scoreboard monitor
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (reg_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: read %h expected %h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_rd(input logic [11:0] a, input logic [31:0] e, input string t);
        reg_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        -> chk_ev;
        #2;
    endtask

    task automatic mark();
        #3;
        base = irq_cnt;
    endtask

    task automatic check_delta(input int d, input string t);
        #3;
        checks++;
        if (irq_cnt - base != d) begin
            errors++;
            $display("FAIL %s: requests %0d expected %0d", t, irq_cnt - base, d);
        end
    endtask

    task automatic check_vec(input logic [7:0] e, input string t);
        #1;
        checks++;
        if (last_vec !== e) begin
            errors++;
            $display("FAIL %s: vector %h expected %h", t, last_vec, e);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        expect_rd(12'h320, 32'h0001_0000, "R1 entry reset");
        expect_rd(12'h380, 32'h0, "R1 start reset");
        expect_rd(12'h390, 32'h0, "R1 live reset");
        expect_rd(12'h3E0, 32'h0, "R1 divide reset");
        expect_rd(12'h0F0, 32'h0000_00FF, "R1 spurious reset");
        mark();
        idle(5);
        check_delta(0, "R1 no request after reset");

        // R10 field retention
        wr(12'h320, 32'hFFFF_FF5A);
        expect_rd(12'h320, 32'h0003_005A, "R10 entry fields");
        wr(12'h3E0, 32'hFFFF_FFFF);
        expect_rd(12'h3E0, 32'h0000_000B, "R10 divide fields");
        wr(12'h0F0, 32'h0000_1234);
        expect_rd(12'h0F0, 32'h0000_0034, "R10 spurious field");
        wr(12'h390, 32'h55);
        expect_rd(12'h390, 32'h0, "R10 live count read-only");

        // R3 R4 R11 one-shot at divide 1
        wr(12'h320, 32'h0000_0031);
        wr(12'h3E0, 32'h0000_000B);
        wr(12'h380, 32'd5);
        mark();
        expect_rd(12'h390, 32'd5, "R3 one-shot at load");
        idle(2);
        expect_rd(12'h390, 32'd3, "R3 one-shot after 2");
        idle(2);
        expect_rd(12'h390, 32'd1, "R3 one-shot after 4");
        check_delta(0, "R4 no early request");
        idle(2);
        expect_rd(12'h390, 32'd0, "R3 one-shot expired");
        check_delta(1, "R4 one request");
        check_vec(8'h31, "R11 one-shot vector");
        idle(20);
        expect_rd(12'h390, 32'd0, "R4 holds zero");
        check_delta(1, "R4 no further request");

        // R5 R6 periodic start 3
        wr(12'h320, 32'h0002_0047);
        wr(12'h380, 32'd3);
        mark();
        expect_rd(12'h390, 32'd3, "R5 periodic at load");
        idle(1);
        expect_rd(12'h390, 32'd2, "R5 periodic after 1");
        idle(2);
        expect_rd(12'h390, 32'd0, "R5 periodic after 3");
        idle(2);
        expect_rd(12'h390, 32'd2, "R5 periodic wrap after 5");
        check_delta(1, "R6 first period");
        idle(13);
        expect_rd(12'h390, 32'd1, "R5 periodic after 18");
        check_delta(4, "R6 four periods");
        check_vec(8'h47, "R11 periodic vector");

        // R9 restart
        wr(12'h380, 32'd9);
        expect_rd(12'h390, 32'd9, "R9 restart load");
        idle(3);
        expect_rd(12'h390, 32'd6, "R9 restart count");
        wr(12'h380, 32'd2);
        idle(1);
        expect_rd(12'h390, 32'd1, "R9 second restart");
        idle(4);

        // R7 zero start in periodic mode
        wr(12'h380, 32'd0);
        mark();
        expect_rd(12'h390, 32'd0, "R7 zero start");
        idle(25);
        expect_rd(12'h390, 32'd0, "R7 stays zero");
        check_delta(0, "R7 no request");

        // R8 mask
        wr(12'h320, 32'h0003_0047);
        wr(12'h380, 32'd2);
        mark();
        idle(19);
        expect_rd(12'h390, 32'd1, "R8 masked still counts");
        check_delta(0, "R8 masked no request");
        wr(12'h320, 32'h0002_0047);
        idle(4);
        expect_rd(12'h390, 32'd1, "R8 count after unmask");
        check_delta(1, "R8 request after unmask");

        // R2 divide codes, one-shot
        wr(12'h320, 32'h0000_0031);
        wr(12'h3E0, 32'h0000_0001);
        wr(12'h380, 32'd10);
        mark();
        idle(9);
        expect_rd(12'h390, 32'd8, "R2 div4 after 9");
        idle(22);
        expect_rd(12'h390, 32'd3, "R2 div4 after 31");
        check_delta(0, "R2 div4 not yet");
        idle(10);
        expect_rd(12'h390, 32'd0, "R2 div4 after 41");
        check_delta(1, "R2 div4 expiry");

        wr(12'h3E0, 32'h0000_0000);
        wr(12'h380, 32'd10);
        idle(7);
        expect_rd(12'h390, 32'd7, "R2 div2 after 7");

        wr(12'h3E0, 32'h0000_0008);
        wr(12'h380, 32'd4);
        idle(70);
        expect_rd(12'h390, 32'd2, "R2 div32 after 70");

        wr(12'h3E0, 32'h0000_000A);
        wr(12'h380, 32'd2);
        mark();
        idle(200);
        expect_rd(12'h390, 32'd1, "R2 div128 after 200");
        idle(60);
        expect_rd(12'h390, 32'd0, "R2 div128 after 260");
        check_delta(1, "R2 div128 expiry");

        // R11 width
        checks++;
        if (max_run != 1) begin
            errors++;
            $display("FAIL R11 request width: %0d expected 1", max_run);
        end

        idle(2);
        finish_run();
    end

endmodule